// File: doc/BRIEF.md
# Register-File ALU Execute Unit

This block is the execute stage of a small 8-bit core. Each cycle it takes one 16-bit instruction word with a valid flag, decodes it, and in the same clock edge writes an 8-bit result into a 32-entry register file and updates two status flags: carry (C) and zero (Z). It supports a load of an immediate constant, add, add-with-carry, subtract, AND, OR and XOR between two registers, and a conditional branch that tests one of the two flags.

The branch is not executed here. The unit evaluates the condition against the current flags and reports a taken indication and the signed offset to the fetch sequencer in the same cycle the branch word is presented. A debug read port exposes any register and both flags so that the surrounding logic, or a bench, can observe the architectural state.

Using the same register as both operands gives well-known aliases with no extra logic: add-with-carry of a register with itself rotates it left through carry, XOR with itself clears it, and AND or OR with itself acts as a zero test.

Top module: `rfx_exec_unit`

## Requirements
- R1: After synchronous reset all 32 registers read 0x00 and both C and Z read 0.
- R2: A valid word with bits 15:12 = 0b1110 loads the constant {bits 11:8, bits 3:0} into register 16 + bits 7:4 after one clock edge; C and Z are not changed.
- R3: For two-register operations the destination is register bits 8:4 and the source is register {bit 9, bits 3:0}; every one of the 32 registers can be either, only the destination is written.
- R4: Bits 15:10 = 0b000011 (add) writes (dst + src) mod 256; C is set when the 9-bit sum exceeds 0xFF, Z when the 8-bit result is zero.
- R5: Bits 15:10 = 0b000111 (add-with-carry) writes (dst + src + C) mod 256 with C and Z as for add; with the same register as both operands this shifts it left, bit 0 taking the old C and the old bit 7 becoming the new C.
- R6: Bits 15:10 = 0b000110 (subtract) writes (dst - src) mod 256; C is set on borrow (src greater than dst), Z when the result is zero.
- R7: Bits 15:10 = 0b001000 (AND), 0b001010 (OR) and 0b001001 (XOR) write the bitwise result, set Z from it and leave C unchanged; XOR of a register with itself yields 0x00 and Z = 1, AND or OR with itself keeps the value.
- R8: A valid word with bits 15:11 = 0b11110 (taken when the flag is 1) or 0b11111 (taken when the flag is 0) and bits 2:0 = 0 (C) or 1 (Z) drives branch_taken high in the same cycle, testing the flags left by earlier instructions, and branch_offset carries bits 10:3 as a signed 8-bit value.
- R9: A word with instr_valid low, any undecoded word such as 0xFFFF, and a branch word whose bits 2:0 are 2 to 7 write no register, change no flag and do not take a branch.
- R10: Every operation completes in one cycle: an instruction may use the result and flags of the instruction issued in the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | The instruction word is to be executed this cycle |
| instr_word | input | 16 | Instruction word |
| branch_taken | output | 1 | The current word is a branch whose condition holds |
| branch_offset | output | 8 | Signed branch offset from bits 10:3 |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 8 | Contents of the selected register |
| dbg_flag_c | output | 1 | Current carry flag |
| dbg_flag_z | output | 1 | Current zero flag |

## Verification
The hardest situation to reach is a chain where a flag written by one instruction is consumed by the next in the following cycle, in particular add-with-carry rotating a register through a carry set by the previous step and a branch deciding on that carry with no idle cycle in between. The stimulus issues a 16-bit addition twice, once below and once above the overflow point, and then rotates a register through the resulting carry back to back, so each consumer sees a flag that was produced only one edge earlier. Self-operand aliases are reached by encoding the same index in both the split source field and the destination field, with the source's upper bit set so the non-adjacent bit 9 is exercised.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int NREGS   = 32;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam int OFFS_W  = 8;

    // Major opcode fields
    localparam logic [3:0] OPC_LDI   = 4'b1110;
    localparam logic [3:0] OPC_BRGRP = 4'b1111;
    localparam logic [5:0] OPC_ADD   = 6'b000011;
    localparam logic [5:0] OPC_ADC   = 6'b000111;
    localparam logic [5:0] OPC_SUB   = 6'b000110;
    localparam logic [5:0] OPC_AND   = 6'b001000;
    localparam logic [5:0] OPC_OR    = 6'b001010;
    localparam logic [5:0] OPC_XOR   = 6'b001001;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_LDI,
        OP_ADD,
        OP_ADC,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_BRANCH
    } op_e;

    typedef struct packed {
        op_e                 op;
        logic [RIDX_W-1:0]   dst;
        logic [RIDX_W-1:0]   src;
        logic [DATA_W-1:0]   imm;
        logic                br_on_clear;
        logic                br_test_z;
        logic [OFFS_W-1:0]   br_offset;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0]   res;
        logic                wr;
        logic                upd_c;
        logic                upd_z;
        logic                c;
        logic                z;
    } alu_out_t;

    function automatic logic [DATA_W-1:0] imm_of(input logic [INSTR_W-1:0] w);
        return {w[11:8], w[3:0]};
    endfunction

    function automatic logic [RIDX_W-1:0] src_of(input logic [INSTR_W-1:0] w);
        return {w[9], w[3:0]};
    endfunction

endpackage

// File: rtl/rfx_decode.sv
module rfx_decode
    import rfx_pkg::*;
(
    input  logic               valid,
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);

    always_comb begin
        dec             = '0;
        dec.op          = OP_NONE;
        dec.dst         = word[8:4];
        dec.src         = src_of(word);
        dec.imm         = imm_of(word);
        dec.br_on_clear = word[11];
        dec.br_test_z   = word[0];
        dec.br_offset   = word[10:3];
        if (valid) begin
            if (word[15:12] == OPC_LDI) begin
                dec.op  = OP_LDI;
                dec.dst = {1'b1, word[7:4]};
            end else if (word[15:12] == OPC_BRGRP) begin
                if (word[2:1] == 2'b00) begin
                    dec.op = OP_BRANCH;
                end
            end else begin
                unique case (word[15:10])
                    OPC_ADD: dec.op = OP_ADD;
                    OPC_ADC: dec.op = OP_ADC;
                    OPC_SUB: dec.op = OP_SUB;
                    OPC_AND: dec.op = OP_AND;
                    OPC_OR:  dec.op = OP_OR;
                    OPC_XOR: dec.op = OP_XOR;
                    default: dec.op = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile #(
    parameter int DATA_W = rfx_pkg::DATA_W,
    parameter int NREGS  = rfx_pkg::NREGS,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [AW-1:0]     rd_d_idx,
    output logic [DATA_W-1:0] rd_d_data
);

    logic [DATA_W-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_idx == AW'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];
    assign rd_d_data = regs[rd_d_idx];

endmodule

// File: rtl/rfx_alu.sv
module rfx_alu
    import rfx_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] imm,
    input  logic              c_in,
    output alu_out_t          out
);

    logic [DATA_W:0] sum_ext;
    logic [DATA_W:0] diff_ext;
    logic            cin_eff;

    assign cin_eff  = (op == OP_ADC) ? c_in : 1'b0;
    assign sum_ext  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin_eff};
    assign diff_ext = {1'b0, a} - {1'b0, b};

    always_comb begin
        out = '0;
        unique case (op)
            OP_LDI: begin
                out.res = imm;
                out.wr  = 1'b1;
            end
            OP_ADD, OP_ADC: begin
                out.res   = sum_ext[DATA_W-1:0];
                out.c     = sum_ext[DATA_W];
                out.wr    = 1'b1;
                out.upd_c = 1'b1;
                out.upd_z = 1'b1;
            end
            OP_SUB: begin
                out.res   = diff_ext[DATA_W-1:0];
                out.c     = diff_ext[DATA_W];
                out.wr    = 1'b1;
                out.upd_c = 1'b1;
                out.upd_z = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (op == OP_AND)      out.res = a & b;
                else if (op == OP_OR)  out.res = a | b;
                else                   out.res = a ^ b;
                out.wr    = 1'b1;
                out.upd_z = 1'b1;
            end
            default: out = '0;
        endcase
        out.z = (out.res == '0);
    end

endmodule

// File: rtl/rfx_exec_unit.sv
module rfx_exec_unit
    import rfx_pkg::*;
#(
    parameter int INSTR_WIDTH = rfx_pkg::INSTR_W,
    parameter int DATA_WIDTH  = rfx_pkg::DATA_W,
    parameter int REG_COUNT   = rfx_pkg::NREGS,
    parameter int OFFS_WIDTH  = rfx_pkg::OFFS_W,
    localparam int IDX_WIDTH  = $clog2(REG_COUNT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   instr_valid,
    input  logic [INSTR_WIDTH-1:0] instr_word,
    output logic                   branch_taken,
    output logic [OFFS_WIDTH-1:0]  branch_offset,
    input  logic [IDX_WIDTH-1:0]   dbg_sel,
    output logic [DATA_WIDTH-1:0]  dbg_data,
    output logic                   dbg_flag_c,
    output logic                   dbg_flag_z
);

    dec_t              dec;
    alu_out_t          alu_o;
    logic [DATA_W-1:0] dst_val;
    logic [DATA_W-1:0] src_val;
    logic              flag_c;
    logic              flag_z;
    logic              tested_flag;

    rfx_decode u_decode (
        .valid (instr_valid),
        .word  (instr_word),
        .dec   (dec)
    );

    rfx_regfile #(
        .DATA_W (DATA_WIDTH),
        .NREGS  (REG_COUNT)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (alu_o.wr),
        .wr_idx    (dec.dst),
        .wr_data   (alu_o.res),
        .rd_a_idx  (dec.dst),
        .rd_a_data (dst_val),
        .rd_b_idx  (dec.src),
        .rd_b_data (src_val),
        .rd_d_idx  (dbg_sel),
        .rd_d_data (dbg_data)
    );

    rfx_alu u_alu (
        .op   (dec.op),
        .a    (dst_val),
        .b    (src_val),
        .imm  (dec.imm),
        .c_in (flag_c),
        .out  (alu_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_c <= 1'b0;
            flag_z <= 1'b0;
        end else begin
            if (alu_o.upd_c) flag_c <= alu_o.c;
            if (alu_o.upd_z) flag_z <= alu_o.z;
        end
    end

    assign tested_flag   = dec.br_test_z ? flag_z : flag_c;
    assign branch_taken  = (dec.op == OP_BRANCH) && (tested_flag != dec.br_on_clear);
    assign branch_offset = dec.br_offset;
    assign dbg_flag_c    = flag_c;
    assign dbg_flag_z    = flag_z;

endmodule

// File: rtl/rfx_exec_checker.sv
module rfx_exec_checker (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [15:0] instr_word,
    input logic        branch_taken,
    input logic        flag_c,
    input logic        flag_z
);

    logic is_ldi, is_logic, is_xor_self, is_br_c_set;

    assign is_ldi      = instr_valid && (instr_word[15:12] == 4'b1110);
    assign is_logic    = instr_valid && ((instr_word[15:10] == 6'b001000) ||
                                         (instr_word[15:10] == 6'b001010) ||
                                         (instr_word[15:10] == 6'b001001));
    assign is_xor_self = instr_valid && (instr_word[15:10] == 6'b001001) &&
                         (instr_word[9] == instr_word[8]) &&
                         (instr_word[3:0] == instr_word[7:4]);
    assign is_br_c_set = instr_valid && (instr_word[15:11] == 5'b11110) &&
                         (instr_word[2:0] == 3'd0);

    AST_LDI_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        is_ldi |=> ($stable(flag_c) && $stable(flag_z))); // R2

    AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        is_logic |=> $stable(flag_c)); // R7

    AST_XOR_SELF_ZERO: assert property (@(posedge clk) disable iff (rst)
        is_xor_self |=> flag_z); // R7

    AST_BRANCH_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
        is_br_c_set |-> (branch_taken == flag_c)); // R8

    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(flag_c) && $stable(flag_z))); // R9

    AST_NO_BRANCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !branch_taken); // R9

endmodule

bind rfx_exec_unit rfx_exec_checker u_rfx_exec_checker (
    .clk          (clk),
    .rst          (rst),
    .instr_valid  (instr_valid),
    .instr_word   (instr_word),
    .branch_taken (branch_taken),
    .flag_c       (dbg_flag_c),
    .flag_z       (dbg_flag_z)
);

// File: tb/rfx_exec_unit_tb_top.sv
module rfx_exec_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic        branch_taken;
    logic [7:0]  branch_offset;
    logic [4:0]  dbg_sel = 5'd0;
    logic [7:0]  dbg_data;
    logic        dbg_flag_c;
    logic        dbg_flag_z;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    bit mon_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfx_exec_unit dut_i (
        .clk           (clk),
        .rst           (rst),
        .instr_valid   (instr_valid),
        .instr_word    (instr_word),
        .branch_taken  (branch_taken),
        .branch_offset (branch_offset),
        .dbg_sel       (dbg_sel),
        .dbg_data      (dbg_data),
        .dbg_flag_c    (dbg_flag_c),
        .dbg_flag_z    (dbg_flag_z)
    );

    typedef struct {
        string      tag;
        logic       exp_br;
        logic [7:0] exp_off;
        int         dreg;
        logic [7:0] exp_val;
        logic       exp_c;
        logic       exp_z;
    } item_t;

    item_t sb_q[$];

    // Reference state built from the requirements
    logic [7:0] m_reg [32];
    logic       m_c;
    logic       m_z;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    function automatic logic [15:0] enc_rr(input logic [5:0] op, input int d, input int s);
        logic [4:0] dd, ss;
        dd = 5'(d);
        ss = 5'(s);
        return {op, ss[4], dd, ss[3:0]};
    endfunction

    function automatic logic [15:0] enc_ldi(input int d, input logic [7:0] k);
        logic [4:0] dd;
        dd = 5'(d);
        return {4'b1110, k[7:4], dd[3:0], k[3:0]};
    endfunction

    function automatic logic [15:0] enc_br(input logic on_clear, input logic [2:0] sel, input logic [7:0] off);
        return {4'b1111, on_clear, off, sel};
    endfunction

    // Driver: computes expectation, pushes it, then drives the word
    task automatic issue(input logic v, input logic [15:0] w, input int view_reg, input string tag);
        item_t      it;
        int         d, s;
        logic [8:0] t;
        logic [7:0] a, b;
        it.tag    = tag;
        it.exp_br = 1'b0;
        it.exp_off = w[10:3];
        it.dreg   = view_reg;
        if (v) begin
            if (w[15:12] == 4'b1110) begin
                d = 16 + int'(w[7:4]);
                m_reg[d] = {w[11:8], w[3:0]};
                it.dreg = d;
            end else if (w[15:12] == 4'b1111) begin
                if (w[2:0] == 3'd0) it.exp_br = w[11] ? !m_c : m_c;
                else if (w[2:0] == 3'd1) it.exp_br = w[11] ? !m_z : m_z;
            end else begin
                d = int'(w[8:4]);
                s = int'({w[9], w[3:0]});
                a = m_reg[d];
                b = m_reg[s];
                case (w[15:10])
                    6'b000011: begin t = {1'b0, a} + {1'b0, b};         m_c = t[8]; m_z = (t[7:0] == 0); m_reg[d] = t[7:0]; it.dreg = d; end
                    6'b000111: begin t = {1'b0, a} + {1'b0, b} + 9'(m_c); m_c = t[8]; m_z = (t[7:0] == 0); m_reg[d] = t[7:0]; it.dreg = d; end
                    6'b000110: begin t = {1'b0, a} - {1'b0, b};         m_c = (b > a); m_z = (t[7:0] == 0); m_reg[d] = t[7:0]; it.dreg = d; end
                    6'b001000: begin m_reg[d] = a & b; m_z = (m_reg[d] == 0); it.dreg = d; end
                    6'b001010: begin m_reg[d] = a | b; m_z = (m_reg[d] == 0); it.dreg = d; end
                    6'b001001: begin m_reg[d] = a ^ b; m_z = (m_reg[d] == 0); it.dreg = d; end
                    default: ;
                endcase
            end
        end
        it.exp_val = m_reg[it.dreg];
        it.exp_c   = m_c;
        it.exp_z   = m_z;
        @(posedge clk);
        #1;
        instr_valid = v;
        instr_word  = w;
        sb_q.push_back(it);
    endtask

    // Monitor: branch checked in the issue cycle, state one edge later
    initial begin
        item_t cur;
        item_t prv;
        bit    have_prv;
        have_prv = 0;
        wait (mon_on);
        forever begin
            @(negedge clk);
            if (have_prv) begin
                dbg_sel = 5'(prv.dreg);
                #1;
                check(prv.tag, "register", int'(dbg_data), int'(prv.exp_val));
                check(prv.tag, "carry", int'(dbg_flag_c), int'(prv.exp_c));
                check(prv.tag, "zero", int'(dbg_flag_z), int'(prv.exp_z));
                have_prv = 0;
            end
            if (sb_q.size() > 0) begin
                cur = sb_q.pop_front();
                check(cur.tag, "branch_taken", int'(branch_taken), int'(cur.exp_br));
                if (cur.exp_br) check(cur.tag, "branch_offset", int'(branch_offset), int'(cur.exp_off));
                prv = cur;
                have_prv = 1;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
        m_c = 1'b0;
        m_z = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 32; i++) begin
            dbg_sel = 5'(i);
            #1;
            check("R1", "reset register", int'(dbg_data), 0);
        end
        check("R1", "reset carry", int'(dbg_flag_c), 0);
        check("R1", "reset zero", int'(dbg_flag_z), 0);
        mon_on = 1;

        // R2 loads, R7 AND to zero, R8 branches on the result
        issue(1, enc_ldi(16, 8'h55), 16, "R2");
        issue(1, enc_ldi(17, 8'hAA), 17, "R2");
        issue(1, enc_rr(6'b001000, 16, 17), 16, "R7");
        issue(1, enc_br(1'b0, 3'd1, 8'h05), 16, "R8");
        issue(1, enc_br(1'b1, 3'd1, 8'h11), 16, "R8");
        issue(1, enc_br(1'b1, 3'd0, 8'hFC), 16, "R8");

        // R4 / R5: 16-bit sum without overflow
        issue(1, enc_ldi(16, 8'h39), 16, "R2");
        issue(1, enc_ldi(17, 8'h30), 17, "R2");
        issue(1, enc_ldi(18, 8'h6E), 18, "R2");
        issue(1, enc_ldi(19, 8'hB2), 19, "R2");
        issue(1, enc_rr(6'b000011, 16, 18), 16, "R4");
        issue(1, enc_rr(6'b000111, 17, 19), 17, "R5");
        issue(1, enc_br(1'b1, 3'd0, 8'h02), 17, "R8");

        // R4 / R5 / R10: 16-bit sum with overflow, carry consumed next cycle
        issue(1, enc_ldi(16, 8'hA0), 16, "R2");
        issue(1, enc_ldi(17, 8'h5B), 17, "R2");
        issue(1, enc_rr(6'b000011, 16, 18), 16, "R4");
        issue(1, enc_rr(6'b000111, 17, 19), 17, "R10");
        issue(1, enc_br(1'b1, 3'd0, 8'h02), 17, "R8");
        issue(1, enc_br(1'b0, 3'd0, 8'h80), 17, "R8");

        // R5 rotate through carry (C=1 survives the load per R2)
        issue(1, enc_ldi(20, 8'h81), 20, "R2");
        issue(1, enc_rr(6'b000111, 20, 20), 20, "R5");
        issue(1, enc_rr(6'b000111, 20, 20), 20, "R5");

        // R6 subtract with borrow and to zero
        issue(1, enc_ldi(21, 8'h10), 21, "R2");
        issue(1, enc_ldi(22, 8'h20), 22, "R2");
        issue(1, enc_rr(6'b000110, 21, 22), 21, "R6");
        issue(1, enc_ldi(23, 8'h20), 23, "R2");
        issue(1, enc_rr(6'b000110, 22, 23), 22, "R6");

        // R3 low registers and split source field with bit 9 set
        issue(1, enc_rr(6'b000011, 0, 21), 0, "R3");
        issue(1, enc_rr(6'b000011, 5, 0), 5, "R3");
        issue(1, enc_rr(6'b000110, 5, 0), 5, "R3");
        issue(1, enc_rr(6'b001010, 31, 0), 31, "R3");
        issue(1, enc_ldi(25, 8'h00), 0, "R3");

        // R7 self-operand aliases, carry held at 1
        issue(1, enc_ldi(24, 8'h01), 24, "R2");
        issue(1, enc_rr(6'b000110, 24, 20), 24, "R6");
        issue(1, enc_rr(6'b001001, 24, 24), 24, "R7");
        issue(1, enc_rr(6'b001010, 20, 20), 20, "R7");
        issue(1, enc_rr(6'b001000, 24, 24), 24, "R7");
        issue(1, enc_rr(6'b001001, 21, 20), 21, "R7");

        // R9 no effect: idle, undecoded, bad flag select
        issue(0, enc_rr(6'b001001, 20, 20), 20, "R9");
        issue(0, enc_br(1'b0, 3'd0, 8'h07), 20, "R9");
        issue(1, 16'hFFFF, 31, "R9");
        issue(1, enc_br(1'b0, 3'd2, 8'h07), 20, "R9");
        issue(1, enc_br(1'b1, 3'd7, 8'h07), 20, "R9");
        issue(1, 16'h0000, 0, "R9");

        issue(0, 16'h0000, 16, "R10");
        issue(0, 16'h0000, 17, "R10");
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule